// File: doc/BRIEF.md
# Instruction Fetch Translation Buffer

This block maps instruction-fetch virtual addresses to physical addresses through a small set-associative translation buffer. Each entry pairs a match word, which holds the virtual page number, a valid flag and an age counter, with a translate word, which holds the physical page number, a cache-inhibit flag and separate execute permissions for supervisor and user mode. The fetch lookup is combinational. On the clock edge after a fetch strobe, the block updates the age counters and pulses a miss exception or a page-fault exception.

Software fills entries through an indexed register port. The port selects a way, a set, and either the match word or the translate word. The same port gives a registered readback of the addressed word. A second lookup port serves debug. It translates an address without touching any state. When translation is off, addresses pass through unchanged and cache inhibit follows the top address bit. A constant configuration word reports the geometry.

Top module: `fetch_xlate_tlb`

## Requirements
- R1: The set index is address bits [PAGE_BITS +: log2(SETS)]. The compared VPN is the address bits above PAGE_BITS+log2(SETS). An entry hits only when its valid bit (match word bit 0) is set and its stored VPN equals the address VPN.
- R2: When more than one way of the set matches, the lowest-numbered way supplies the translation.
- R3: When xlat_on is low, phys_addr equals fetch_addr, fetch_hit is 0, and fetch_ci equals fetch_addr bit 31, so it is set exactly for addresses at or above 0x80000000.
- R4: On a hit, phys_addr is the translate word's bits [31:PAGE_BITS] joined with the address's low PAGE_BITS bits, and fetch_ci is translate word bit 1.
- R5: On a strobed hit, pf_exc pulses in the following cycle when the execute bit for the current mode is clear. Supervisor mode uses translate bit 6 and user mode uses translate bit 7.
- R6: On a miss with translation on, phys_addr and fetch_ci are 0 and a strobed fetch pulses miss_exc in the following cycle. A miss changes no entry.
- R7: Each way's age field sits in match word bits [6 +: log2(SETS)]. On a strobed hit, every other way of that set with a nonzero age decrements by one, and the hit way's age becomes SETS-1. Without a strobe the ages do not change.
- R8: cfg_word bits [1:0] hold WAYS-1, bits [6:3] hold log2(SETS), and all other bits are 0.
- R9: dbg_paddr is the translation of dbg_addr. It is 0 on a miss or a permission failure, and it equals dbg_addr when translation is off. A debug lookup changes no age and raises no exception.
- R10: Reset clears every match word, so every lookup misses and readback returns 0. A register write becomes visible in reg_rdata one cycle after the write.
- R11: miss_exc and pf_exc assert only in the cycle after a fetch strobe made with xlat_on high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_stb | input | 1 | Fetch strobe |
| fetch_addr | input | 32 | Fetch virtual address |
| xlat_on | input | 1 | Translation enable |
| sup_mode | input | 1 | Supervisor mode |
| reg_we | input | 1 | Entry write enable |
| reg_sel | input | 1 | 0 selects the match word, 1 selects the translate word |
| reg_way | input | WAY_W | Way index for write and readback |
| reg_set | input | SET_W | Set index for write and readback |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered readback of the addressed word |
| dbg_addr | input | 32 | Debug lookup address |
| dbg_paddr | output | 32 | Debug lookup result |
| phys_addr | output | 32 | Translated fetch address |
| fetch_ci | output | 1 | Cache inhibit for the fetch |
| fetch_hit | output | 1 | Fetch hit |
| miss_exc | output | 1 | Translation-miss exception pulse |
| pf_exc | output | 1 | Page-fault exception pulse |
| cfg_word | output | 32 | Constant geometry word |

## Verification
The assertions assume that reset is applied first. They also assume that fetch_addr, xlat_on and sup_mode stay stable from the strobed cycle until the following edge, because the exception and age checks look back one cycle. The bench changes inputs only on falling edges and holds each fetch for a full cycle. The age-reload check assumes that no software write to the same match word lands in the same cycle. The bench never overlaps a register write with a strobed fetch.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int AW        = 32;
  localparam int MW_VALID  = 0;
  localparam int MW_AGE_LO = 6;
  localparam int TW_CI     = 1;
  localparam int TW_SX     = 6;
  localparam int TW_UX     = 7;

  function automatic logic exec_ok(input logic [AW-1:0] tw, input logic sup);
    return sup ? tw[TW_SX] : tw[TW_UX];
  endfunction
endpackage

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int WAYS  = 2,
  parameter int VPN_W = 17,
  parameter int WAY_W = 1
) (
  input  logic [VPN_W-1:0]             vpn,
  input  logic [WAYS-1:0]              way_valid,
  input  logic [WAYS-1:0][VPN_W-1:0]   way_vpn,
  input  logic [WAYS-1:0][31:0]        way_tw,
  output logic                         hit,
  output logic [WAY_W-1:0]             hit_way,
  output logic [31:0]                  hit_tw
);
  // scan from the top down so the lowest matching way is taken last and wins
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    hit_tw  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_valid[w] && way_vpn[w] == vpn) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
        hit_tw  = way_tw[w];
      end
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int VPN_W = 17,
  parameter int AGE_W = 2,
  parameter int WAY_W = 1,
  parameter int SET_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic                        sel,
  input  logic [WAY_W-1:0]            wway,
  input  logic [SET_W-1:0]            wset,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  input  logic                        upd_en,
  input  logic [SET_W-1:0]            upd_set,
  input  logic [WAY_W-1:0]            upd_way,
  input  logic [SET_W-1:0]            f_set,
  output logic [WAYS-1:0]             f_valid,
  output logic [WAYS-1:0][VPN_W-1:0]  f_vpn,
  output logic [WAYS-1:0][31:0]       f_tw,
  input  logic [SET_W-1:0]            d_set,
  output logic [WAYS-1:0]             d_valid,
  output logic [WAYS-1:0][VPN_W-1:0]  d_vpn,
  output logic [WAYS-1:0][31:0]       d_tw
);
  import tlb_pkg::*;
  localparam int VPN_LO = 32 - VPN_W;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SETS - 1);

  logic                valid_q [WAYS][SETS];
  logic [AGE_W-1:0]    age_q   [WAYS][SETS];
  logic [VPN_W-1:0]    vpn_q   [WAYS][SETS];
  logic [31:0]         tw_q    [WAYS][SETS];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      for (int s = 0; s < SETS; s++) begin
        if (rst) begin
          valid_q[w][s] <= 1'b0;
          age_q[w][s]   <= '0;
          vpn_q[w][s]   <= '0;
        end else if (we && !sel && wway == WAY_W'(w) && wset == SET_W'(s)) begin
          valid_q[w][s] <= wdata[MW_VALID];
          age_q[w][s]   <= wdata[MW_AGE_LO +: AGE_W];
          vpn_q[w][s]   <= wdata[31:VPN_LO];
        end else if (upd_en && upd_set == SET_W'(s)) begin
          if (upd_way == WAY_W'(w))
            age_q[w][s] <= AGE_MAX;
          else if (age_q[w][s] != '0)
            age_q[w][s] <= age_q[w][s] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we && sel) tw_q[wway][wset] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (sel) rdata <= tw_q[wway][wset];
    else begin
      rdata <= '0;
      rdata[31:VPN_LO] <= vpn_q[wway][wset];
      rdata[MW_AGE_LO +: AGE_W] <= age_q[wway][wset];
      rdata[MW_VALID] <= valid_q[wway][wset];
    end
  end

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_rd
      assign f_valid[gw] = valid_q[gw][f_set];
      assign f_vpn[gw]   = vpn_q[gw][f_set];
      assign f_tw[gw]    = tw_q[gw][f_set];
      assign d_valid[gw] = valid_q[gw][d_set];
      assign d_vpn[gw]   = vpn_q[gw][d_set];
      assign d_tw[gw]    = tw_q[gw][d_set];
    end
  endgenerate

  logic             upd_q, mw_wr_q;
  logic [SET_W-1:0] upd_set_q;
  logic [WAY_W-1:0] upd_way_q;
  logic             vwr_q;
  logic [SET_W-1:0] vset_q;
  logic [WAY_W-1:0] vway_q;
  always_ff @(posedge clk) begin
    upd_q     <= upd_en && !rst;
    mw_wr_q   <= we && !sel;
    upd_set_q <= upd_set;
    upd_way_q <= upd_way;
    vwr_q     <= we && !sel && wdata[MW_VALID] && !rst;
    vset_q    <= wset;
    vway_q    <= wway;
  end

  // R7
  age_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_q && !mw_wr_q) |-> age_q[upd_way_q][upd_set_q] == AGE_MAX);
  // R10
  valid_write_chk: assert property (@(posedge clk) disable iff (rst)
    vwr_q |-> valid_q[vway_q][vset_q]);
endmodule

// File: rtl/fetch_xlate_tlb.sv
module fetch_xlate_tlb #(
  parameter int WAYS      = 2,
  parameter int SETS      = 4,
  parameter int PAGE_BITS = 13,
  parameter bit PRESENT   = 1'b1,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W    = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_stb,
  input  logic [31:0]      fetch_addr,
  input  logic             xlat_on,
  input  logic             sup_mode,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [WAY_W-1:0] reg_way,
  input  logic [SET_W-1:0] reg_set,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [31:0]      dbg_addr,
  output logic [31:0]      dbg_paddr,
  output logic [31:0]      phys_addr,
  output logic             fetch_ci,
  output logic             fetch_hit,
  output logic             miss_exc,
  output logic             pf_exc,
  output logic [31:0]      cfg_word
);
  import tlb_pkg::*;
  localparam int SET_LOG = $clog2(SETS);
  localparam int VPN_LO  = PAGE_BITS + SET_LOG;
  localparam int VPN_W   = 32 - VPN_LO;
  localparam int AGE_W   = (SET_LOG > 0) ? SET_LOG : 1;

  logic active;
  assign active = xlat_on && PRESENT;

  function automatic logic [SET_W-1:0] set_of(input logic [31:0] a);
    return (SETS > 1) ? a[PAGE_BITS +: SET_W] : '0;
  endfunction

  logic [SET_W-1:0]           f_set, d_set;
  logic [WAYS-1:0]            f_valid, d_valid;
  logic [WAYS-1:0][VPN_W-1:0] f_vpn, d_vpn;
  logic [WAYS-1:0][31:0]      f_tw, d_tw;
  logic                       f_hit, d_hit;
  logic [WAY_W-1:0]           f_way, d_way;
  logic [31:0]                f_sel_tw, d_sel_tw;
  logic                       upd_en;

  assign f_set  = set_of(fetch_addr);
  assign d_set  = set_of(dbg_addr);
  assign upd_en = fetch_stb && active && f_hit;

  tlb_store #(.WAYS(WAYS), .SETS(SETS), .VPN_W(VPN_W), .AGE_W(AGE_W),
              .WAY_W(WAY_W), .SET_W(SET_W)) u_store (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wway(reg_way),
    .wset(reg_set), .wdata(reg_wdata), .rdata(reg_rdata),
    .upd_en(upd_en), .upd_set(f_set), .upd_way(f_way),
    .f_set(f_set), .f_valid(f_valid), .f_vpn(f_vpn), .f_tw(f_tw),
    .d_set(d_set), .d_valid(d_valid), .d_vpn(d_vpn), .d_tw(d_tw));

  tlb_lookup #(.WAYS(WAYS), .VPN_W(VPN_W), .WAY_W(WAY_W)) u_fetch_lk (
    .vpn(fetch_addr[31:VPN_LO]), .way_valid(f_valid), .way_vpn(f_vpn),
    .way_tw(f_tw), .hit(f_hit), .hit_way(f_way), .hit_tw(f_sel_tw));

  tlb_lookup #(.WAYS(WAYS), .VPN_W(VPN_W), .WAY_W(WAY_W)) u_dbg_lk (
    .vpn(dbg_addr[31:VPN_LO]), .way_valid(d_valid), .way_vpn(d_vpn),
    .way_tw(d_tw), .hit(d_hit), .hit_way(d_way), .hit_tw(d_sel_tw));

  always_comb begin
    fetch_hit = active && f_hit;
    if (!active) begin
      phys_addr = fetch_addr;
      fetch_ci  = fetch_addr[31];
    end else if (f_hit) begin
      phys_addr = {f_sel_tw[31:PAGE_BITS], fetch_addr[PAGE_BITS-1:0]};
      fetch_ci  = f_sel_tw[TW_CI];
    end else begin
      phys_addr = '0;
      fetch_ci  = 1'b0;
    end
  end

  always_comb begin
    if (!active)
      dbg_paddr = dbg_addr;
    else if (d_hit && exec_ok(d_sel_tw, sup_mode))
      dbg_paddr = {d_sel_tw[31:PAGE_BITS], dbg_addr[PAGE_BITS-1:0]};
    else
      dbg_paddr = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_exc <= 1'b0;
      pf_exc   <= 1'b0;
    end else begin
      miss_exc <= fetch_stb && active && !f_hit;
      pf_exc   <= fetch_stb && active && f_hit && !exec_ok(f_sel_tw, sup_mode);
    end
  end

  always_comb begin
    cfg_word       = '0;
    cfg_word[1:0]  = 2'(WAYS - 1);
    cfg_word[6:3]  = 4'(SET_LOG);
  end

  // R11
  exc_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_exc || pf_exc) |-> $past(fetch_stb && xlat_on));
  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    !xlat_on |-> (phys_addr == fetch_addr && fetch_ci == fetch_addr[31] && !fetch_hit));
  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (xlat_on && PRESENT && !fetch_hit) |-> (phys_addr == '0 && !fetch_ci));
  // R5
  pf_hit_chk: assert property (@(posedge clk) disable iff (rst)
    pf_exc |-> !miss_exc);
endmodule

// File: tb/test_fetch_xlate_tlb.sv
module test_fetch_xlate_tlb;
  logic        clk = 0;
  logic        rst = 1;
  logic        fetch_stb = 0;
  logic [31:0] fetch_addr = 0;
  logic        xlat_on = 0, sup_mode = 0;
  logic        reg_we = 0, reg_sel = 0;
  logic [0:0]  reg_way = 0;
  logic [1:0]  reg_set = 0;
  logic [31:0] reg_wdata = 0, dbg_addr = 0;
  logic [31:0] reg_rdata, dbg_paddr, phys_addr, cfg_word;
  logic        fetch_ci, fetch_hit, miss_exc, pf_exc;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fetch_xlate_tlb i_fetch_xlate_tlb (
    .clk(clk), .rst(rst), .fetch_stb(fetch_stb), .fetch_addr(fetch_addr),
    .xlat_on(xlat_on), .sup_mode(sup_mode), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_way(reg_way), .reg_set(reg_set), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dbg_addr(dbg_addr), .dbg_paddr(dbg_paddr),
    .phys_addr(phys_addr), .fetch_ci(fetch_ci), .fetch_hit(fetch_hit),
    .miss_exc(miss_exc), .pf_exc(pf_exc), .cfg_word(cfg_word));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int way, input int set, input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_way = 1'(way); reg_set = 2'(set); reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_chk(input int way, input int set, input bit sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_way = 1'(way); reg_set = 2'(set); reg_sel = sel;
    @(negedge clk);
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic fetch(input logic [31:0] a, input bit on, input bit sup, input bit stb);
    @(negedge clk);
    fetch_addr = a; xlat_on = on; sup_mode = sup; fetch_stb = stb;
    #1;
  endtask

  task automatic fetch_end();
    @(negedge clk);
    fetch_stb = 0;
  endtask

  localparam int NV = 11;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000A123, 32'h0000A123, 32'h00012456, 32'h00012456,
    32'h0001C010, 32'h00026000, 32'h0002A001, 32'h00012456, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFE004};
  localparam bit V_ON  [NV] = '{1,1,1,1,1,1,1,0,0,0,0};
  localparam bit V_SUP [NV] = '{1,0,0,1,1,1,0,1,1,0,1};
  localparam bit V_HIT [NV] = '{1,1,1,1,1,0,0,0,0,0,0};
  localparam logic [31:0] V_PHYS [NV] = '{32'h40000123, 32'h40000123, 32'h80002456, 32'h80002456,
    32'h11110010, 32'h0, 32'h0, 32'h00012456, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFE004};
  localparam bit V_CI   [NV] = '{0,0,1,1,0,0,0,0,1,0,1};
  localparam bit V_PF   [NV] = '{0,1,0,0,0,0,0,0,0,0,0};
  localparam bit V_MISS [NV] = '{0,0,0,0,0,1,1,0,0,0,0};
  localparam string V_TAG [NV] = '{"R4 R5 sup", "R5 user pf", "R4 ci", "R4 R5 sup",
    "R2 first way", "R1 invalid", "R1 R6 vpn", "R3 off", "R3 ci edge", "R3 below", "R3 high"};

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk(reg_rdata === 32'h0 && !miss_exc && !pf_exc, "R10 reset outputs", reg_rdata, 0);
    chk(cfg_word === 32'h11, "R8 cfg", cfg_word, 32'h11);
    rd_chk(0, 1, 0, 32'h0, "R10 match cleared");
    fetch(32'h0000A123, 1, 1, 1);
    chk(!fetch_hit && phys_addr === 0, "R10 miss after reset", phys_addr, 0);
    fetch_end();
    chk(miss_exc === 1, "R6 miss exc", miss_exc, 1);

    wr(0, 1, 0, 32'h00008001); wr(0, 1, 1, 32'h40000040);
    wr(1, 1, 0, 32'h00010001); wr(1, 1, 1, 32'h800020C2);
    wr(0, 2, 0, 32'h00018001); wr(0, 2, 1, 32'h11110040);
    wr(1, 2, 0, 32'h00018001); wr(1, 2, 1, 32'h22220040);
    wr(0, 3, 0, 32'h00020000); wr(0, 3, 1, 32'h33330040);
    rd_chk(1, 1, 1, 32'h800020C2, "R10 readback tw");

    for (int i = 0; i < NV; i++) begin
      fetch(V_ADDR[i], V_ON[i], V_SUP[i], 1);
      chk(fetch_hit === V_HIT[i], V_TAG[i], 32'(fetch_hit), 32'(V_HIT[i]));
      chk(phys_addr === V_PHYS[i], V_TAG[i], phys_addr, V_PHYS[i]);
      chk(fetch_ci === V_CI[i], V_TAG[i], 32'(fetch_ci), 32'(V_CI[i]));
      fetch_end();
      chk(pf_exc === V_PF[i], V_TAG[i], 32'(pf_exc), 32'(V_PF[i]));
      chk(miss_exc === V_MISS[i], V_TAG[i], 32'(miss_exc), 32'(V_MISS[i]));
    end

    // R7 ageing
    wr(0, 1, 0, 32'h00008081); wr(1, 1, 0, 32'h00010001);
    fetch(32'h00012456, 1, 1, 1); fetch_end();
    rd_chk(0, 1, 0, 32'h00008041, "R7 other way decrements");
    rd_chk(1, 1, 0, 32'h000100C1, "R7 hit way reload");
    fetch(32'h0000A123, 1, 1, 0); fetch_end();
    chk(!miss_exc && !pf_exc, "R11 no strobe no exc", 32'(miss_exc), 0);
    rd_chk(0, 1, 0, 32'h00008041, "R7 no strobe no change");
    fetch(32'h0002A001, 1, 1, 1); fetch_end();
    rd_chk(0, 1, 0, 32'h00008041, "R6 miss no change w0");
    rd_chk(1, 1, 0, 32'h000100C1, "R6 miss no change w1");
    fetch(32'h0000A123, 1, 1, 1); fetch_end();
    rd_chk(0, 1, 0, 32'h000080C1, "R7 reload way0");
    rd_chk(1, 1, 0, 32'h00010081, "R7 decrement way1");
    fetch(32'h00026000, 0, 1, 1); fetch_end();
    chk(!miss_exc, "R11 off no exc", 32'(miss_exc), 0);

    // R9 debug port
    @(negedge clk);
    fetch_stb = 0; xlat_on = 1; sup_mode = 1; dbg_addr = 32'h00012456; #1;
    chk(dbg_paddr === 32'h80002456, "R9 dbg hit", dbg_paddr, 32'h80002456);
    sup_mode = 0; dbg_addr = 32'h0000A123; #1;
    chk(dbg_paddr === 32'h0, "R9 dbg perm", dbg_paddr, 0);
    dbg_addr = 32'h00026000; #1;
    chk(dbg_paddr === 32'h0, "R9 dbg miss", dbg_paddr, 0);
    xlat_on = 0; dbg_addr = 32'hDEAD0000; #1;
    chk(dbg_paddr === 32'hDEAD0000, "R9 dbg off", dbg_paddr, 32'hDEAD0000);
    @(negedge clk);
    chk(!miss_exc && !pf_exc, "R9 dbg no exc", 32'(pf_exc), 0);
    rd_chk(0, 1, 0, 32'h000080C1, "R9 dbg no age change");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule